// File: doc/BRIEF.md
# Byte ALU with Flag Generation

This block is the combinational arithmetic and logic unit of a small accumulator-style processor. It takes an accumulator byte, a second operand byte, a 4-bit operation code and the incoming carry and half-carry flags. In the same evaluation it returns an 8-bit result, a status byte holding the new flag values, and a matching write-enable byte. The write-enable byte marks the flags that the operation changes.

Subtraction uses the same 9-bit adder as addition, fed with the inverted operand. Compare and the two bit-test operations reuse that subtract path to form their flags. The shift unit and the decimal-adjust unit are separate small datapaths. A final multiplexer picks the result and assembles the flags. The status byte places N at bit 7, V at bit 6, H at bit 3, Z at bit 1 and C at bit 0, so that a neighbouring flag register can merge it directly under the write-enable mask. Bits 5, 4 and 2 are reserved for state held outside this block. They and their enables are always 0. Any flag bit whose enable is 0 is also driven as 0.

Top module: `byte_alu`

## Requirements
- R1: Operation code 0 (add with carry) returns A + B + carry_i modulo 256. C receives bit 8 of the 9-bit sum, and the enables for N, V, H, Z and C are all set.
- R2: Operation code 1 (subtract with borrow) returns A + ~B + carry_i modulo 256, so carry_i = 1 means no borrow. C = 1 after the operation means no borrow occurred. It writes the same five flags as R1.
- R3: For codes 0 and 1, H is the carry out of bit 3, that is bit 4 of A ^ B' ^ sum, where B' is the operand after any inversion. V is set when the two adder inputs share a sign that differs from the sign of the 8-bit sum.
- R4: Operation code 2 (compare) forms A − B with a forced carry-in of 1, ignoring carry_i. It sets C when there is no borrow and sets N and Z from the difference. It returns A unchanged as the result, and the V and H enables stay 0 (enable byte 0x83).
- R5: Codes 3, 4 and 5 return A & B, A | B and A ^ B. Code 6 (move) returns B. All four write only N and Z (enable byte 0x82) and ignore carry_i and half_i.
- R6: On A, code 7 shifts left with 0 in, code 8 rotates left through carry, code 9 shifts right with 0 in and code 10 rotates right through carry. C receives the bit shifted out, and N, Z and C are written (0x83).
- R7: Code 11 swaps the two nibbles of A and writes only N and Z.
- R8: Code 12 (decimal adjust after add) first adds 0x60 and sets C when A > 0x99 or carry_i = 1, and otherwise passes carry_i to C. It then adds 0x06 when the low nibble exceeds 9 or half_i = 1. The result is taken modulo 256, and N, Z and C are written.
- R9: Code 13 (decimal adjust after subtract) first subtracts 0x60 and clears C when A > 0x99 or carry_i = 0, and otherwise passes carry_i to C. It then subtracts 0x06 when the low nibble exceeds 9 or half_i = 0. N, Z and C are written.
- R10: Code 14 (test and set) returns B | A and code 15 (test and clear) returns B & ~A. Both take N and Z from the low byte of A − B, not from the result, and leave C unwritten (0x82).
- R11: In status_o, N is bit 7, V bit 6, H bit 3, Z bit 1 and C bit 0. Bits 5, 4 and 2 and their enables are always 0, and every bit whose enable is 0 reads 0. Outside R4 and R10, N is result bit 7 and Z is set exactly when the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (0 to 15 as listed in the requirements) |
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Second operand B (memory byte for the bit-test operations) |
| carry_i | input | 1 | Incoming carry flag |
| half_i | input | 1 | Incoming half-carry flag |
| result_o | output | 8 | Result byte |
| status_o | output | 8 | New flag values in status-byte positions |
| status_we_o | output | 8 | Per-bit write enable for status_o |

## Verification
Decimal adjust can apply both of its corrections in one evaluation. The high correction can also push the low-nibble correction across a byte boundary. The bench provokes this with A = 0x9A and with A = 0xFF for the add form, and with A = 0x15 and both flags clear for the subtract form. It judges the wrapped result, the forced carry and the Z/N bits against values worked out by hand. The bit-test operations likewise produce a logical result and subtract-derived flags together. Vectors where the difference and the result disagree in sign or zeroness, such as A = 0x80 and B = 0x00, show that each output is taken from its own path.

// File: rtl/alu_pkg.sv
// Shared widths, operation codes and status-byte bit positions for the byte ALU.
// Assumes an 8-bit datapath split into two 4-bit nibbles.
package alu_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 4;

    // Status byte bit positions (decoded by the flag register next door)
    localparam int ST_N = 7;
    localparam int ST_V = 6;
    localparam int ST_H = 3;
    localparam int ST_Z = 1;
    localparam int ST_C = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADC  = 4'd0,
        OP_SBC  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_MOV  = 4'd6,
        OP_ASL  = 4'd7,
        OP_ROL  = 4'd8,
        OP_LSR  = 4'd9,
        OP_ROR  = 4'd10,
        OP_XCN  = 4'd11,
        OP_DAA  = 4'd12,
        OP_DAS  = 4'd13,
        OP_TSET = 4'd14,
        OP_TCLR = 4'd15
    } alu_op_e;
endpackage

// File: rtl/alu_adder.sv
// Carry-propagate adder with optional operand inversion.
// Produces the W-bit sum, carry out, carry out of the low nibble and signed overflow.
// Assumes W is even; subtraction is requested by inverting b and supplying cin = 1.
module alu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         inv_b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         half_o,
    output logic         ovf_o
);
    localparam int HB = W / 2;

    logic [W-1:0] b_eff;
    logic [W:0]   full;
    logic [W:0]   xor_all;

    // Form the effective operand and the extended sum
    always_comb begin
        b_eff   = inv_b_i ? ~b_i : b_i;
        full    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
        xor_all = {1'b0, a_i} ^ {1'b0, b_eff} ^ full;
    end

    // Extract sum and flag bits
    always_comb begin
        sum_o  = full[W-1:0];
        cout_o = full[W];
        half_o = xor_all[HB];
        ovf_o  = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu_shift.sv
// One-position shifter for the accumulator.
// dir_left_i selects direction; rotate_i feeds the old carry in instead of 0.
// The bit shifted out is returned as the new carry.
module alu_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    input  logic         dir_left_i,
    input  logic         rotate_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    logic fill;

    // Choose fill bit and shift
    always_comb begin
        fill = rotate_i & cin_i;
        if (dir_left_i) begin
            res_o  = {a_i[W-2:0], fill};
            cout_o = a_i[W-1];
        end else begin
            res_o  = {fill, a_i[W-1:1]};
            cout_o = a_i[0];
        end
    end
endmodule

// File: rtl/alu_decadj.sv
// Two-step decimal correction of the accumulator after an add or a subtract.
// Step one corrects the high digit and the carry; step two corrects the low digit.
// Assumes an 8-bit byte; all sums wrap modulo 256.
module alu_decadj
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic              cin_i,
    input  logic              hin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    localparam logic [DATA_W-1:0] HI_ADJ   = 8'h60;
    localparam logic [DATA_W-1:0] LO_ADJ   = 8'h06;
    localparam logic [DATA_W-1:0] MAX_BCD  = 8'h99;
    localparam logic [NIB_W-1:0]  MAX_DIG  = 4'd9;

    logic              hi_fix;
    logic              lo_fix;
    logic [DATA_W-1:0] stage1;

    // High-digit step: condition, correction and carry
    always_comb begin
        if (sub_i) hi_fix = (a_i > MAX_BCD) || !cin_i;
        else       hi_fix = (a_i > MAX_BCD) ||  cin_i;
        if (!hi_fix)    stage1 = a_i;
        else if (sub_i) stage1 = a_i - HI_ADJ;
        else            stage1 = a_i + HI_ADJ;
        cout_o = hi_fix ? !sub_i : cin_i;
    end

    // Low-digit step applied to the first-stage value
    always_comb begin
        if (sub_i) lo_fix = (stage1[NIB_W-1:0] > MAX_DIG) || !hin_i;
        else       lo_fix = (stage1[NIB_W-1:0] > MAX_DIG) ||  hin_i;
        if (!lo_fix)    res_o = stage1;
        else if (sub_i) res_o = stage1 - LO_ADJ;
        else            res_o = stage1 + LO_ADJ;
    end
endmodule

// File: rtl/byte_alu.sv
// Byte ALU top: routes operands to the adder, shifter and decimal-adjust units,
// selects the result and builds the status byte and its write-enable mask.
// Purely combinational; assumes the caller merges status_o under status_we_o.
module byte_alu
    import alu_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              carry_i,
    input  logic              half_i,
    output logic [DATA_W-1:0] result_o,
    output logic [7:0]        status_o,
    output logic [7:0]        status_we_o
);
    alu_op_e           op;
    logic              add_inv;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum;
    logic              add_cout;
    logic              add_half;
    logic              add_ovf;
    logic              sh_left;
    logic              sh_rot;
    logic [DATA_W-1:0] sh_res;
    logic              sh_cout;
    logic              da_sub;
    logic [DATA_W-1:0] da_res;
    logic              da_cout;
    logic [DATA_W-1:0] res;
    logic [DATA_W-1:0] nz_src;
    logic              c_new;
    logic              v_new;
    logic              h_new;
    logic              we_n, we_v, we_h, we_z, we_c;

    // Decode adder control from the operation
    always_comb begin
        op      = alu_op_e'(op_i);
        add_inv = (op != OP_ADC);
        add_cin = (op == OP_ADC || op == OP_SBC) ? carry_i : 1'b1;
        sh_left = (op == OP_ASL || op == OP_ROL);
        sh_rot  = (op == OP_ROL || op == OP_ROR);
        da_sub  = (op == OP_DAS);
    end

    alu_adder #(.W(DATA_W)) adder_i (
        .a_i     (acc_i),
        .b_i     (opnd_i),
        .inv_b_i (add_inv),
        .cin_i   (add_cin),
        .sum_o   (add_sum),
        .cout_o  (add_cout),
        .half_o  (add_half),
        .ovf_o   (add_ovf)
    );

    alu_shift #(.W(DATA_W)) shift_i (
        .a_i        (acc_i),
        .cin_i      (carry_i),
        .dir_left_i (sh_left),
        .rotate_i   (sh_rot),
        .res_o      (sh_res),
        .cout_o     (sh_cout)
    );

    alu_decadj decadj_i (
        .a_i    (acc_i),
        .cin_i  (carry_i),
        .hin_i  (half_i),
        .sub_i  (da_sub),
        .res_o  (da_res),
        .cout_o (da_cout)
    );

    // Result selection, flag sources and write-enable decode
    always_comb begin
        res   = acc_i;
        c_new = 1'b0;
        v_new = 1'b0;
        h_new = 1'b0;
        we_n  = 1'b1;
        we_z  = 1'b1;
        we_v  = 1'b0;
        we_h  = 1'b0;
        we_c  = 1'b0;
        unique case (op)
            OP_ADC, OP_SBC: begin
                res   = add_sum;
                c_new = add_cout;
                v_new = add_ovf;
                h_new = add_half;
                we_v  = 1'b1;
                we_h  = 1'b1;
                we_c  = 1'b1;
            end
            OP_CMP: begin
                res   = acc_i;
                c_new = add_cout;
                we_c  = 1'b1;
            end
            OP_AND:  res = acc_i & opnd_i;
            OP_OR:   res = acc_i | opnd_i;
            OP_XOR:  res = acc_i ^ opnd_i;
            OP_MOV:  res = opnd_i;
            OP_ASL, OP_ROL, OP_LSR, OP_ROR: begin
                res   = sh_res;
                c_new = sh_cout;
                we_c  = 1'b1;
            end
            OP_XCN:  res = {acc_i[NIB_W-1:0], acc_i[DATA_W-1:NIB_W]};
            OP_DAA, OP_DAS: begin
                res   = da_res;
                c_new = da_cout;
                we_c  = 1'b1;
            end
            OP_TSET: res = opnd_i | acc_i;
            OP_TCLR: res = opnd_i & ~acc_i;
            default: res = acc_i;
        endcase
        if (op == OP_CMP || op == OP_TSET || op == OP_TCLR) nz_src = add_sum;
        else                                                 nz_src = res;
    end

    // Assemble status byte and mask in their fixed bit positions
    always_comb begin
        result_o          = res;
        status_o          = '0;
        status_we_o       = '0;
        status_we_o[ST_N] = we_n;
        status_we_o[ST_V] = we_v;
        status_we_o[ST_H] = we_h;
        status_we_o[ST_Z] = we_z;
        status_we_o[ST_C] = we_c;
        status_o[ST_N]    = we_n & nz_src[DATA_W-1];
        status_o[ST_V]    = we_v & v_new;
        status_o[ST_H]    = we_h & h_new;
        status_o[ST_Z]    = we_z & (nz_src == '0);
        status_o[ST_C]    = we_c & c_new;
    end
endmodule

// File: rtl/byte_alu_chk.sv
// Property checker for the byte ALU; attached to every instance by bind.
// Assumes inputs are stable when evaluated (combinational block, immediate checks).
module byte_alu_chk
    import alu_pkg::*;
(
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic              carry_i,
    input logic              half_i,
    input logic [DATA_W-1:0] result_o,
    input logic [7:0]        status_o,
    input logic [7:0]        status_we_o
);
    logic [DATA_W:0] ref_add;
    logic [DATA_W:0] ref_sub;
    logic            diff_flags;

    // Evaluate properties whenever any input or output moves
    always_comb begin
        ref_add    = {1'b0, acc_i} + {1'b0, opnd_i} + {{DATA_W{1'b0}}, carry_i};
        ref_sub    = {1'b0, acc_i} + {1'b0, ~opnd_i} + {{DATA_W{1'b0}}, carry_i};
        diff_flags = (op_i == OP_CMP) || (op_i == OP_TSET) || (op_i == OP_TCLR);
        if (!$isunknown({op_i, acc_i, opnd_i, carry_i, half_i})) begin
            // R1
            adc_sum_chk: assert (op_i != OP_ADC || {status_o[ST_C], result_o} == ref_add)
                else $error("adc sum/carry mismatch");
            // R2
            sbc_sum_chk: assert (op_i != OP_SBC || {status_o[ST_C], result_o} == ref_sub)
                else $error("sbc sum/carry mismatch");
            // R4
            cmp_keep_chk: assert (op_i != OP_CMP || (result_o == acc_i && status_we_o == 8'h83))
                else $error("compare altered result or enables");
            // R7
            xcn_swap_chk: assert (op_i != OP_XCN || result_o == {acc_i[3:0], acc_i[7:4]})
                else $error("nibble swap wrong");
            // R10
            tset_bits_chk: assert (op_i != OP_TSET || (result_o & acc_i) == acc_i)
                else $error("test-and-set left a bit clear");
            // R10
            tclr_bits_chk: assert (op_i != OP_TCLR || (result_o & acc_i) == '0)
                else $error("test-and-clear left a bit set");
            // R11
            reserved_zero_chk: assert ((status_we_o & 8'h34) == '0 && (status_o & ~status_we_o) == '0)
                else $error("reserved or unwritten status bit driven");
            // R11
            zn_result_chk: assert (diff_flags ||
                                   (status_o[ST_Z] == (result_o == '0) && status_o[ST_N] == result_o[7]))
                else $error("N/Z disagree with result");
        end
    end
endmodule

bind byte_alu byte_alu_chk chk_i (
    .op_i        (op_i),
    .acc_i       (acc_i),
    .opnd_i      (opnd_i),
    .carry_i     (carry_i),
    .half_i      (half_i),
    .result_o    (result_o),
    .status_o    (status_o),
    .status_we_o (status_we_o)
);

// File: tb/byte_alu_tb_top.sv
// Self-checking bench for byte_alu: a vector table walked by one loop,
// then directed checks for the idle state and corner cases.
module byte_alu_tb_top;
    localparam int NVEC = 32;
    localparam int VW   = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic       carry_i = 1'b0;
    logic       half_i = 1'b0;
    logic [7:0] result_o;
    logic [7:0] status_o;
    logic [7:0] status_we_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    byte_alu dut_i (
        .op_i        (op_i),
        .acc_i       (acc_i),
        .opnd_i      (opnd_i),
        .carry_i     (carry_i),
        .half_i      (half_i),
        .result_o    (result_o),
        .status_o    (status_o),
        .status_we_o (status_we_o)
    );

    // Vector: {req4, op4, a8, b8, c1, h1, res8, flags8, we8}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {4'd1,  4'd0,  8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h02, 8'hCB},
        {4'd3,  4'd0,  8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 8'hC8, 8'hCB},
        {4'd1,  4'd0,  8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 8'h0B, 8'hCB},
        {4'd1,  4'd0,  8'h12, 8'h34, 1'b1, 1'b1, 8'h47, 8'h00, 8'hCB},
        {4'd3,  4'd1,  8'h50, 8'h10, 1'b1, 1'b0, 8'h40, 8'h09, 8'hCB},
        {4'd2,  4'd1,  8'h00, 8'h01, 1'b1, 1'b0, 8'hFF, 8'h80, 8'hCB},
        {4'd3,  4'd1,  8'h80, 8'h01, 1'b1, 1'b0, 8'h7F, 8'h41, 8'hCB},
        {4'd2,  4'd1,  8'h10, 8'h05, 1'b0, 1'b0, 8'h0A, 8'h01, 8'hCB},
        {4'd4,  4'd2,  8'h30, 8'h30, 1'b0, 1'b1, 8'h30, 8'h03, 8'h83},
        {4'd4,  4'd2,  8'h10, 8'h20, 1'b1, 1'b0, 8'h10, 8'h80, 8'h83},
        {4'd5,  4'd3,  8'hF0, 8'h3C, 1'b1, 1'b1, 8'h30, 8'h00, 8'h82},
        {4'd5,  4'd4,  8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h02, 8'h82},
        {4'd5,  4'd5,  8'hFF, 8'h0F, 1'b0, 1'b0, 8'hF0, 8'h80, 8'h82},
        {4'd5,  4'd6,  8'h55, 8'h00, 1'b1, 1'b0, 8'h00, 8'h02, 8'h82},
        {4'd6,  4'd7,  8'h81, 8'h00, 1'b1, 1'b0, 8'h02, 8'h01, 8'h83},
        {4'd6,  4'd8,  8'h81, 8'h00, 1'b1, 1'b0, 8'h03, 8'h01, 8'h83},
        {4'd6,  4'd9,  8'h01, 8'h00, 1'b1, 1'b0, 8'h00, 8'h03, 8'h83},
        {4'd6,  4'd10, 8'h01, 8'h00, 1'b1, 1'b0, 8'h80, 8'h81, 8'h83},
        {4'd6,  4'd10, 8'h02, 8'h00, 1'b0, 1'b0, 8'h01, 8'h00, 8'h83},
        {4'd7,  4'd11, 8'h3C, 8'h00, 1'b0, 1'b0, 8'hC3, 8'h80, 8'h82},
        {4'd8,  4'd12, 8'h15, 8'h00, 1'b0, 1'b0, 8'h15, 8'h00, 8'h83},
        {4'd8,  4'd12, 8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 8'h03, 8'h83},
        {4'd8,  4'd12, 8'h40, 8'h00, 1'b1, 1'b0, 8'hA0, 8'h81, 8'h83},
        {4'd8,  4'd12, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h65, 8'h01, 8'h83},
        {4'd9,  4'd13, 8'h15, 8'h00, 1'b1, 1'b1, 8'h15, 8'h01, 8'h83},
        {4'd9,  4'd13, 8'h15, 8'h00, 1'b0, 1'b0, 8'hAF, 8'h80, 8'h83},
        {4'd9,  4'd13, 8'h2B, 8'h00, 1'b1, 1'b1, 8'h25, 8'h01, 8'h83},
        {4'd10, 4'd14, 8'h0F, 8'hF0, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h82},
        {4'd10, 4'd14, 8'h10, 8'h10, 1'b0, 1'b0, 8'h10, 8'h02, 8'h82},
        {4'd10, 4'd15, 8'h0F, 8'hFF, 1'b1, 1'b0, 8'hF0, 8'h00, 8'h82},
        {4'd10, 4'd15, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 8'h80, 8'h82},
        {4'd11, 4'd6,  8'h00, 8'h80, 1'b0, 1'b0, 8'h80, 8'h80, 8'h82}
    };

    function automatic string req_name(input int r);
        case (r)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";  10: return "R10"; 11: return "R11";
            default: return "R?";
        endcase
    endfunction

    // Drive inputs at a falling edge, sample shortly after
    task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic c, input logic h);
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; carry_i = c; half_i = h;
        #1;
    endtask

    task automatic check3(input string req, input logic [7:0] er, input logic [7:0] ef,
                          input logic [7:0] ew);
        checks++;
        if (result_o !== er || status_o !== ef || status_we_o !== ew) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h: got res=%h st=%h we=%h, expected res=%h st=%h we=%h",
                     req, op_i, acc_i, opnd_i, result_o, status_o, status_we_o, er, ef, ew);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] r0, s0, w0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state after reset: all-zero inputs select add of zeros (R1)
        #1;
        check3("R1", 8'h00, 8'h02, 8'hCB);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][45:42], VEC[i][41:34], VEC[i][33:26], VEC[i][25], VEC[i][24]);
            check3(req_name(int'(VEC[i][49:46])), VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
        end

        // R5: carry_i and half_i have no effect on AND
        apply(4'd3, 8'hA5, 8'h0F, 1'b0, 1'b0);
        r0 = result_o; s0 = status_o; w0 = status_we_o;
        apply(4'd3, 8'hA5, 8'h0F, 1'b1, 1'b1);
        check3("R5", r0, s0, w0);

        // R4: carry_i ignored by compare (forced carry-in)
        apply(4'd2, 8'h05, 8'h05, 1'b0, 1'b0);
        check3("R4", 8'h05, 8'h03, 8'h83);

        // R2: subtract with carry clear takes one extra from 0x00 - 0x00
        apply(4'd1, 8'h00, 8'h00, 1'b0, 1'b0);
        check3("R2", 8'hFF, 8'h80, 8'hCB);

        // R11: reserved bits and unwritten flags stay clear for every code
        for (int k = 0; k < 16; k++) begin
            apply(k[3:0], 8'h99, 8'h66, 1'b1, 1'b1);
            checks++;
            if ((status_we_o & 8'h34) != 0 || (status_o & ~status_we_o) != 0) begin
                errors++;
                $display("FAIL R11 op=%0d: got st=%h we=%h, expected reserved/unwritten bits 0",
                         k, status_o, status_we_o);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule